// File: doc/BRIEF.md
# Mask Set-First Segment Unit

This block turns a bit mask into a derived mask by scanning from bit 0 upward and locating the first set bit of a source word. The result takes one of three shapes. It can mark every position below that first set bit. It can mark those positions and the set bit itself. Or it can mark only the set bit. Vector code uses these shapes as predicate masks, for example to run a loop body only up to the first element that meets a condition.

A second mask, the restart predicate, is enabled with `pred_en`. When it is enabled, each set predicate bit re-arms the search at its own position. One word can therefore hold many independent segments, and each segment gets its own first-hit treatment. When it is disabled, the whole word is one segment that starts armed at bit 0.

The unit has no clock. Its result is a pure function of the present inputs. It is built as a logarithmic-depth parallel prefix over per-bit arm and pass-through terms.

Top module: `msf_unit`

## Requirements
- R1: Mode code 2'b00 selects set-before-first. A result bit is 1 where the search is active and the source bit is 0. The first source 1 of a segment and every later position up to the next restart are 0. Example: source 0x94 gives 0x03.
- R2: Mode code 2'b01 selects set-including-first. It matches R1 and, in addition, sets the position of the first source 1. Example: source 0x94 gives 0x07 and source 0x95 gives 0x01.
- R3: Mode code 2'b10 selects set-only-first. Each segment sets only the position of its first source 1, so with `pred_en` low the result has at most one bit set. Example: source 0x94 gives 0x04.
- R4: With `pred_en` low and a source of all zeros, set-before-first and set-including-first both give all ones, and set-only-first gives zero.
- R5: While `pred_en` is 0 the `pred` input has no effect on `result`, and the search is armed at bit 0.
- R6: While `pred_en` is 1, the search is armed at bit 0 only if `pred[0]` is 1. Positions below the lowest set predicate bit are 0 in the result.
- R7: While `pred_en` is 1, a predicate bit set at position i after the search has stopped restarts the search at position i, and bit i itself takes part in the new search.
- R8: A predicate bit that arrives while the search is still active does not change the result.
- R9: Mode code 2'b11 is reserved. It forces `result` to zero and raises `illegal`. The other three codes keep `illegal` at 0.
- R10: `result` and `illegal` follow the inputs combinationally, with no clock or storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src | input | 64 | Source mask scanned for first set bit |
| pred | input | 64 | Restart predicate mask, one bit per position |
| pred_en | input | 1 | 1 = use `pred` for restarts, 0 = single segment |
| mode | input | 2 | 00 before-first, 01 including-first, 10 only-first, 11 reserved |
| result | output | 64 | Derived destination mask |
| illegal | output | 1 | High when the reserved mode code is applied |

## Verification
The bench targets four corner cases:
- A set bit at position 0 or 63. An off-by-one in the scan would shift a hit into a neighbouring position or lose it.
- An all-zero source. A design that mishandles the no-hit case would return zero instead of all ones for the first two modes.
- A predicate bit landing exactly on a source 1, and a predicate bit landing inside a still-active search. A design that mis-orders the restart against the hit test would mark the wrong positions or end the segment early.
- Segments whose predicate is set but `pred_en` is low. A design that leaked the predicate would split the word into segments.

Random sparse masks in all four mode codes are compared against a bit-serial reference.

// File: rtl/msf_pkg.sv
package msf_pkg;

  typedef enum logic [1:0] {
    MSF_BEFORE = 2'b00,
    MSF_INCL   = 2'b01,
    MSF_ONLY   = 2'b10,
    MSF_RSVD   = 2'b11
  } msf_mode_e;

endpackage

// File: rtl/msf_seed.sv
// Per-bit arm (generate) and pass-through (propagate) terms of the scan.
// The search is active at bit i when bit i arms it, or when it was active
// at bit i-1 and src[i-1] did not stop it.
module msf_seed #(
  parameter int W = 64
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] pred,
  input  logic         pred_en,
  output logic [W-1:0] arm,
  output logic [W-1:0] pass
);

  // bit 0: armed unconditionally in single-segment use, else by pred[0]
  assign arm[0]  = pred_en ? pred[0] : 1'b1;
  assign pass[0] = 1'b0;

  genvar b;
  generate
    for (b = 1; b < W; b++) begin : g_bit
      assign arm[b]  = pred_en & pred[b];
      assign pass[b] = ~src[b-1];
    end
  endgenerate

endmodule

// File: rtl/msf_prefix_scan.sv
// Kogge-Stone prefix over (arm, pass) pairs: act[i] = arm[i] | pass[i] & act[i-1].
module msf_prefix_scan #(
  parameter int W = 64
) (
  input  logic [W-1:0] arm,
  input  logic [W-1:0] pass,
  output logic [W-1:0] act
);

  localparam int LEVELS = (W > 1) ? $clog2(W) : 1;

  always_comb begin
    logic [W-1:0] g;
    logic [W-1:0] p;
    g = arm;
    p = pass;
    for (int lv = 0; lv < LEVELS; lv++) begin
      // high to low so every bit reads the previous level of its partner
      for (int b = W - 1; b >= (1 << lv); b--) begin
        g[b] = g[b] | (p[b] & g[b - (1 << lv)]);
        p[b] = p[b] & p[b - (1 << lv)];
      end
    end
    act = g;
  end

endmodule

// File: rtl/msf_mode_sel.sv
// Shapes the active-search vector into the selected destination mask.
module msf_mode_sel
  import msf_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] act,
  input  logic [W-1:0] src,
  input  logic [1:0]   mode,
  output logic [W-1:0] result,
  output logic         illegal
);

  msf_mode_e mode_e;
  assign mode_e  = msf_mode_e'(mode);
  assign illegal = (mode_e == MSF_RSVD);

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      always_comb begin
        unique case (mode_e)
          MSF_BEFORE: result[b] = act[b] & ~src[b];
          MSF_INCL:   result[b] = act[b];
          MSF_ONLY:   result[b] = act[b] & src[b];
          default:    result[b] = 1'b0;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/msf_unit.sv
module msf_unit
  import msf_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] pred,
  input  logic         pred_en,
  input  logic [1:0]   mode,
  output logic [W-1:0] result,
  output logic         illegal
);

  logic [W-1:0] arm;
  logic [W-1:0] pass;
  logic [W-1:0] act;

  msf_seed #(.W(W)) u_seed (
    .src     (src),
    .pred    (pred),
    .pred_en (pred_en),
    .arm     (arm),
    .pass    (pass)
  );

  msf_prefix_scan #(.W(W)) u_scan (
    .arm  (arm),
    .pass (pass),
    .act  (act)
  );

  msf_mode_sel #(.W(W)) u_sel (
    .act     (act),
    .src     (src),
    .mode    (mode),
    .result  (result),
    .illegal (illegal)
  );

endmodule

// File: rtl/msf_unit_chk.sv
module msf_unit_chk #(
  parameter int W = 64
) (
  input logic [W-1:0] src,
  input logic [W-1:0] pred,
  input logic         pred_en,
  input logic [1:0]   mode,
  input logic [W-1:0] result,
  input logic         illegal
);

  logic [W-1:0] lowest;
  assign lowest = src & (~src + 1'b1);

  always_comb begin
    if (mode == 2'b11) begin
      assert_rsvd_zero_R9: assert (illegal && result == '0);
    end else begin
      assert_legal_flag_R9: assert (!illegal);
    end
    if (mode == 2'b00) begin
      assert_before_no_src_R1: assert ((result & src) == '0);
    end
    if (mode == 2'b10) begin
      assert_only_on_src_R3: assert ((result & ~src) == '0);
    end
    if (mode == 2'b10 && !pred_en) begin
      assert_only_single_R3: assert ($onehot0(result));
    end
    if (mode == 2'b01 && !pred_en) begin
      assert_incl_shape_R2: assert (result == (src == '0 ? '1 : (lowest | (lowest - 1'b1))));
    end
    if (mode == 2'b00 && !pred_en && src == '0) begin
      assert_zero_src_ones_R4: assert (result == '1);
    end
    if (pred_en && mode != 2'b11 && pred != '0) begin
      assert_below_first_arm_R6: assert ((result & ((pred & (~pred + 1'b1)) - 1'b1)) == '0);
    end
  end

endmodule

bind msf_unit msf_unit_chk #(.W(W)) u_chk (.*);

// File: tb/msf_unit_test.sv
module msf_unit_test;

  localparam int W = 64;

  logic         clk;
  logic [W-1:0] src;
  logic [W-1:0] pred;
  logic         pred_en;
  logic [1:0]   mode;
  logic [W-1:0] result;
  logic         illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  msf_unit #(.W(W)) uut (
    .src     (src),
    .pred    (pred),
    .pred_en (pred_en),
    .mode    (mode),
    .result  (result),
    .illegal (illegal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bit-serial reference, written from the requirements
  function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [W-1:0] p,
                                         input logic pe, input logic [1:0] m);
    logic [W-1:0] r;
    bit searching;
    r = '0;
    searching = 0;
    if (m == 2'b11) return '0;
    for (int i = 0; i < W; i++) begin
      if (pe ? p[i] : (i == 0)) searching = 1;
      if (searching) begin
        if (s[i]) begin
          if (m != 2'b00) r[i] = 1'b1;
          searching = 0;
        end else if (m != 2'b10) begin
          r[i] = 1'b1;
        end
      end
    end
    return r;
  endfunction

  task automatic apply(input logic [W-1:0] s, input logic [W-1:0] p, input logic pe,
                       input logic [1:0] m, input string tag);
    logic [W-1:0] exp_r;
    @(negedge clk);
    src = s; pred = p; pred_en = pe; mode = m;
    @(posedge clk);
    #2;
    exp_r = model(s, p, pe, m);
    n_checks++;
    if (result !== exp_r || illegal !== (m == 2'b11)) begin
      n_fail++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               tag, result, illegal, exp_r, (m == 2'b11));
    end
  endtask

  task automatic expect_val(input logic [W-1:0] exp_r, input string tag);
    n_checks++;
    if (result !== exp_r) begin
      n_fail++;
      $display("FAIL %s: result=%h expected=%h", tag, result, exp_r);
    end
  endtask

  initial begin
    src = '0; pred = '0; pred_en = 1'b0; mode = 2'b00;
    #15;
    // R4 initial state: zero source, before-first
    expect_val('1, "R4 initial zero src");

    // R1 R2 R3 document-style examples
    apply(64'h94, '0, 1'b0, 2'b00, "R1 before 0x94");
    expect_val(64'h03, "R1 literal 0x94");
    apply(64'h94, '0, 1'b0, 2'b01, "R2 incl 0x94");
    expect_val(64'h07, "R2 literal 0x94");
    apply(64'h95, '0, 1'b0, 2'b01, "R2 incl 0x95");
    apply(64'h95, '0, 1'b0, 2'b00, "R1 before 0x95");
    apply(64'h94, '0, 1'b0, 2'b10, "R3 only 0x94");
    expect_val(64'h04, "R3 literal 0x94");

    // R4 zero source in each mode, and a top-bit-only source
    apply('0, '0, 1'b0, 2'b01, "R4 incl zero");
    apply('0, '0, 1'b0, 2'b10, "R4 only zero");
    apply(64'h8000_0000_0000_0000, '0, 1'b0, 2'b00, "R1 hit at 63");

    // R5 predicate ignored when disabled
    apply(64'h94, 64'hFFFF_0000_F0F0_1234, 1'b0, 2'b00, "R5 pred ignored");
    expect_val(64'h03, "R5 pred ignored literal");

    // R6 no arm at bit 0
    apply(64'h94, 64'h100, 1'b1, 2'b01, "R6 late arm");
    apply(64'h0, '0, 1'b1, 2'b00, "R6 no pred bits");
    expect_val('0, "R6 no pred bits literal");

    // R7 restarts in several segments
    apply(64'h94, 64'hC3, 1'b1, 2'b00, "R7 before segments");
    apply(64'hD4, 64'hC3, 1'b1, 2'b10, "R7 only segments");
    apply(64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101, 1'b1, 2'b00, "R7 restart on hit");
    apply(64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 1'b1, 2'b01, "R7 edge bits");

    // R8 predicate inside an active search
    apply(64'h80, 64'h0000_0000_0000_0015, 1'b1, 2'b01, "R8 pred while active");
    expect_val(64'hFF, "R8 literal");

    // R9 reserved mode
    apply(64'h94, 64'hFF, 1'b1, 2'b11, "R9 reserved");
    apply('0, '0, 1'b0, 2'b11, "R9 reserved zero");

    // R10 combinational follow without a clock edge
    @(negedge clk);
    src = 64'h10; pred_en = 1'b0; mode = 2'b00;
    #1;
    expect_val(64'h0F, "R10 no clock needed");

    // random sparse patterns, all modes
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] s;
      logic [W-1:0] p;
      s = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      p = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      apply(s, p, 1'($urandom), 2'($urandom), "R1/R2/R3/R7 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule